// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block serializes words of 7, 8 or 9 bits onto a single asynchronous line. A holding buffer accepts one word from the host side. While transmission is enabled, the word is moved into a shift register on a bit-period tick from an external rate generator. The line then carries a low start bit, the data bits, an optional parity bit and one or two high stop bits, each lasting one tick period. The frame format is taken from the control inputs at the moment the word moves into the shift register.

The buffer and the shift register together form a double buffer. Software can write the next word while the current frame is still going out. That next word follows the last stop bit with no idle gap. Two flags report buffer-empty and shift-register-empty. A single interrupt line pulses on whichever of those two events is selected.

Top module: `sertx_top`

## Requirements
- R1: After reset, txd is 1, buf_empty is 1, shift_empty is 1 and irq is 0.
- R2: fmt_len selects the data length: 3'b100 gives 7 bits, 3'b101 gives 8 bits, 3'b110 gives 9 bits, and any other code is treated as 8 bits. Bits 0 upward of the buffered word are sent.
- R3: fmt_two_stop = 0 sends one high stop bit and fmt_two_stop = 1 sends two.
- R4: With fmt_par_en = 1, one parity bit follows the last data bit. With fmt_par_odd = 0 it makes the count of ones in data plus parity even; with fmt_par_odd = 1 it makes that count odd.
- R5: fmt_msb_first = 1 sends bit 7 first only for 8-bit frames. 7-bit and 9-bit frames are always sent bit 0 first.
- R6: The first bit on the line is a low start bit, followed in order by data, parity and stop bits. txd changes only after a clock edge at which bit_tick was 1, and each bit lasts one tick period.
- R7: A buffered word moves into the shift register only at a tick while tx_en is 1. With tx_en at 0 the word stays buffered and the line stays high.
- R8: A write (wr_valid) makes buf_empty 0 in the next cycle. buf_empty returns to 1 in the cycle in which the word moves to the shift register.
- R9: shift_empty goes to 0 when a frame is loaded and returns to 1 one tick period after the last stop bit starts. If a word is buffered and tx_en is 1, its start bit begins on that same tick with no idle gap.
- R10: irq is a one-cycle pulse. With irq_on_done = 0 it follows each load from the buffer. With irq_on_done = 1 it follows each frame completion. It appears in the same cycle as the matching flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| tx_en | input | 1 | Allows new frames to start |
| fmt_len | input | 3 | Data length code |
| fmt_two_stop | input | 1 | 1 selects two stop bits |
| fmt_par_en | input | 1 | Parity bit enable |
| fmt_par_odd | input | 1 | 1 selects odd parity, 0 even |
| fmt_msb_first | input | 1 | MSB-first order (8-bit frames only) |
| irq_on_done | input | 1 | Interrupt source: 1 frame complete, 0 buffer empty |
| wr_valid | input | 1 | Write strobe for the transmit buffer |
| wr_data | input | 9 | Word to transmit |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Transmit buffer has no pending word |
| shift_empty | output | 1 | No frame in flight |
| irq | output | 1 | Transmit interrupt pulse |

## Verification
On every cycle, the checker confirms several timing rules. The line moves only after a tick. Every load starts with a low bit, happens at a tick and needs tx_en. A write always leaves the buffer marked full. Each interrupt pulse matches an earlier full buffer or an earlier busy shifter, depending on the selected source.

Only the bench scenarios can show that the bit sequence is correct for each length, parity, stop and order setting. The same holds for the seamless join of two queued frames and for the word held back while tx_en is low. Those checks compare whole captured frames against hand-derived patterns.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
    localparam int DATA_MAX = 9;
    localparam int STOP_MAX = 2;
    localparam int FRAME_W  = 1 + DATA_MAX + 1 + STOP_MAX;
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    localparam logic [2:0] LEN_CODE_7 = 3'b100;
    localparam logic [2:0] LEN_CODE_8 = 3'b101;
    localparam logic [2:0] LEN_CODE_9 = 3'b110;

    typedef struct packed {
        logic [2:0] len;
        logic       two_stop;
        logic       par_en;
        logic       par_odd;
        logic       msb_first;
    } fmt_t;
endpackage

// File: rtl/sertx_buf.sv
module sertx_buf
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                take,
    output logic                full,
    output logic [DATA_MAX-1:0] word
);
    typedef struct packed {
        logic                full;
        logic [DATA_MAX-1:0] word;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take) st_d.full = 1'b0;
        if (wr_valid) begin
            st_d.full = 1'b1;
            st_d.word = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full = st_q.full;
    assign word = st_q.word;
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
    import sertx_pkg::*;
(
    input  logic [DATA_MAX-1:0] word,
    input  fmt_t                fmt,
    output logic [FRAME_W-1:0]  frame,
    output logic [CNT_W-1:0]    nbits
);
    logic [CNT_W-1:0]    dlen;
    logic [DATA_MAX-1:0] ordered;
    logic [DATA_MAX-1:0] mask;
    logic                par_bit;

    always_comb begin
        unique case (fmt.len)
            LEN_CODE_7: dlen = CNT_W'(7);
            LEN_CODE_9: dlen = CNT_W'(9);
            default:    dlen = CNT_W'(8);
        endcase
    end

    always_comb begin
        ordered = word;
        if (dlen == CNT_W'(8) && fmt.msb_first) begin
            for (int i = 0; i < 8; i++) ordered[i] = word[7-i];
        end
    end

    always_comb begin
        for (int i = 0; i < DATA_MAX; i++) mask[i] = (i < int'(dlen));
        par_bit = (^(ordered & mask)) ^ fmt.par_odd;
    end

    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < int'(dlen)) frame[1+i] = ordered[i];
        end
        if (fmt.par_en) frame[1+int'(dlen)] = par_bit;
        nbits = CNT_W'(2) + dlen + CNT_W'(fmt.par_en) + CNT_W'(fmt.two_stop);
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bit_tick,
    input  logic               req,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    output logic               load,
    output logic               done,
    output logic               busy,
    output logic               txd
);
    typedef struct packed {
        logic               busy;
        logic               txd;
        logic [CNT_W-1:0]   left;
        logic [FRAME_W-1:0] sh;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         last;

    assign last = st_q.busy && (st_q.left == '0);
    assign done = bit_tick && last;
    assign load = bit_tick && req && (!st_q.busy || last);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.sh   = frame;
            st_d.left = nbits - CNT_W'(1);
            st_d.txd  = frame[0];
        end else if (done) begin
            st_d.busy = 1'b0;
            st_d.txd  = 1'b1;
        end else if (bit_tick && st_q.busy) begin
            st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
            st_d.left = st_q.left - CNT_W'(1);
            st_d.txd  = st_q.sh[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.txd  <= 1'b1;
            st_q.sh   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign txd  = st_q.txd;
endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_tick,
    input  logic                tx_en,
    input  logic [2:0]          fmt_len,
    input  logic                fmt_two_stop,
    input  logic                fmt_par_en,
    input  logic                fmt_par_odd,
    input  logic                fmt_msb_first,
    input  logic                irq_on_done,
    input  logic                wr_valid,
    input  logic [DATA_MAX-1:0] wr_data,
    output logic                txd,
    output logic                buf_empty,
    output logic                shift_empty,
    output logic                irq
);
    typedef struct packed {
        logic irq;
    } top_state_t;

    top_state_t          st_d, st_q;
    fmt_t                fmt;
    logic                buf_full;
    logic [DATA_MAX-1:0] buf_word;
    logic [FRAME_W-1:0]  frame;
    logic [CNT_W-1:0]    nbits;
    logic                load, done, busy;

    assign fmt = '{len: fmt_len, two_stop: fmt_two_stop, par_en: fmt_par_en,
                   par_odd: fmt_par_odd, msb_first: fmt_msb_first};

    sertx_buf buf_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .take(load), .full(buf_full), .word(buf_word)
    );

    sertx_frame frame_i (
        .word(buf_word), .fmt(fmt), .frame(frame), .nbits(nbits)
    );

    sertx_shift shift_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .req(buf_full && tx_en),
        .frame(frame), .nbits(nbits), .load(load), .done(done),
        .busy(busy), .txd(txd)
    );

    always_comb begin
        st_d.irq = irq_on_done ? done : load;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq         = st_q.irq;
    assign buf_empty   = !buf_full;
    assign shift_empty = !busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic tx_en,
    input logic irq_on_done,
    input logic wr_valid,
    input logic txd,
    input logic buf_empty,
    input logic shift_empty,
    input logic irq
);
    // R6: the line moves only after a tick edge
    p_line_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (txd != $past(txd)) |-> $past(bit_tick));

    // R6: every load begins with a low start bit
    p_start_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !txd);

    // R7: loads need tx_en
    p_load_enabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> $past(tx_en));

    // R9: shifter leaves idle only at a tick
    p_load_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> $past(bit_tick));

    // R8: a write leaves the buffer full
    p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !buf_empty);

    // R10: completion pulse only after a busy shifter
    p_irq_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq_on_done)) |-> !$past(shift_empty));

    // R10: buffer-empty pulse only after a full buffer
    p_irq_buf_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(irq_on_done)) |-> !$past(buf_empty));
endmodule

bind sertx_top sertx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
    .irq_on_done(irq_on_done), .wr_valid(wr_valid), .txd(txd),
    .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
);

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;
    localparam int DIV = 4;
    localparam int NV  = 7;
    // cfg = {len[2:0], two_stop, par_en, par_odd, msb_first, word[8:0]}
    localparam logic [15:0] VEC_CFG [NV] = '{
        {3'b101, 1'b0, 1'b0, 1'b0, 1'b0, 9'h0A5},   // R2 8-bit LSB
        {3'b101, 1'b0, 1'b0, 1'b0, 1'b1, 9'h0C1},   // R5 8-bit MSB
        {3'b100, 1'b1, 1'b1, 1'b0, 1'b1, 9'h1C1},   // R2 R3 R4 R5 7-bit
        {3'b110, 1'b0, 1'b1, 1'b1, 1'b0, 9'h155},   // R2 R4 9-bit odd
        {3'b101, 1'b1, 1'b1, 1'b0, 1'b0, 9'h0FF},   // R3 R4 even
        {3'b101, 1'b0, 1'b1, 1'b1, 1'b0, 9'h000},   // R4 odd zero
        {3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 9'h001}    // R2 other code
    };
    // exp = {nbits[3:0], line bits, first bit at [12]}
    localparam logic [16:0] VEC_EXP [NV] = '{
        {4'd10, 13'b0101001011000},
        {4'd10, 13'b0110000011000},
        {4'd11, 13'b0100000101100},
        {4'd12, 13'b0101010101010},
        {4'd12, 13'b0111111110110},
        {4'd11, 13'b0000000001100},
        {4'd10, 13'b0100000001000}
    };

    logic       clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0, tx_en = 1'b0;
    logic [2:0] fmt_len = 3'b101;
    logic       fmt_two_stop = 1'b0, fmt_par_en = 1'b0, fmt_par_odd = 1'b0;
    logic       fmt_msb_first = 1'b0, irq_on_done = 1'b0, wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       txd, buf_empty, shift_empty, irq;
    int         checks = 0, fails = 0, tick_cnt = 0, cycles = 0;
    logic       finished = 1'b0;

    always #5 clk = ~clk;

    always @(negedge clk) begin
        tick_cnt <= (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;
        bit_tick <= (tick_cnt == DIV - 1);
    end

    sertx_top dut_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .fmt_len(fmt_len), .fmt_two_stop(fmt_two_stop), .fmt_par_en(fmt_par_en),
        .fmt_par_odd(fmt_par_odd), .fmt_msb_first(fmt_msb_first),
        .irq_on_done(irq_on_done), .wr_valid(wr_valid), .wr_data(wr_data),
        .txd(txd), .buf_empty(buf_empty), .shift_empty(shift_empty), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [8:0] w);
        wr_data  = w;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic next_tick();
        do @(negedge clk); while (!bit_tick);
    endtask

    task automatic apply_cfg(input logic [15:0] c);
        {fmt_len, fmt_two_stop, fmt_par_en, fmt_par_odd, fmt_msb_first} = c[15:9];
    endtask

    task automatic run_frame(input logic [15:0] c, input logic [16:0] e,
                             input logic mode, input string req);
        logic [12:0] got = '0;
        int          n = int'(e[16:13]);
        apply_cfg(c);
        irq_on_done = mode;
        write_word(c[8:0]);
        check(buf_empty == 1'b0, "R8 write clears", buf_empty, 0);
        while (shift_empty) @(negedge clk);
        check(buf_empty && irq == !mode, "R8 R10 at load", {buf_empty, irq}, {1'b1, !mode});
        got[12] = txd;
        for (int k = 1; k < n; k++) begin
            next_tick();
            got[12-k] = txd;
        end
        check(got == e[12:0], req, got, e[12:0]);
        next_tick();
        check(shift_empty && txd && irq == mode, "R9 R10 at end",
              {shift_empty, txd, irq}, {2'b11, mode});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(txd && buf_empty && shift_empty && !irq, "R1 reset",
              {txd, buf_empty, shift_empty, irq}, 4'b1110);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd && buf_empty && shift_empty && !irq, "R1 after release",
              {txd, buf_empty, shift_empty, irq}, 4'b1110);
        tx_en = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_frame(VEC_CFG[i], VEC_EXP[i], 1'(i % 2), "R2 R3 R4 R5 R6 frame");
            repeat (3) @(negedge clk);
        end

        // R7: disabled transmitter holds the word
        tx_en = 1'b0;
        apply_cfg(VEC_CFG[0]);
        write_word(9'h0A5);
        repeat (4 * DIV) @(negedge clk);
        check(shift_empty && !buf_empty && txd, "R7 held while disabled",
              {shift_empty, buf_empty, txd}, 3'b101);
        tx_en = 1'b1;
        while (shift_empty) @(negedge clk);
        check(!txd && buf_empty, "R7 starts once enabled", {txd, buf_empty}, 2'b01);
        repeat (9) next_tick();
        next_tick();
        check(shift_empty && txd, "R7 frame finished", {shift_empty, txd}, 2'b11);

        // R9: back-to-back frames with no idle gap
        begin
            logic [12:0] got = '0;
            irq_on_done = 1'b1;
            apply_cfg(VEC_CFG[0]);
            write_word(9'h0A5);
            while (shift_empty) @(negedge clk);
            write_word(9'h0C1);
            repeat (9) next_tick();
            next_tick();
            check(!shift_empty && !txd && irq && buf_empty, "R9 no gap",
                  {shift_empty, txd, irq, buf_empty}, 4'b0011);
            got[12] = txd;
            for (int k = 1; k < 10; k++) begin
                next_tick();
                got[12-k] = txd;
            end
            check(got == 13'b0100000111000, "R9 second frame", got, 13'b0100000111000);
            next_tick();
            check(shift_empty && irq, "R10 second done", {shift_empty, irq}, 2'b11);
            @(negedge clk);
            check(!irq, "R10 single pulse", irq, 0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule